// File: doc/BRIEF.md
# Two-Stage Multi-Request Output Arbiter

This block arbitrates output ports for a 16-port crossbar. Each input port can post one pending request, and that request may name several output ports at once, as a port card with virtual output queues or priority queues would. A request is settled in two word clocks. In the first, every requested output that is free and not already held is reserved for one port. A global rotating priority over input ports settles contention for an output. In the second, each port that holds reservations keeps one of them, chosen by its own round-robin pointer. It gives the others back in that same cycle. A request that wins nothing stays pending and is tried again on every later cycle.

On a win, the port gets a one-clock acknowledge pulse. On the following clock, the number of the granted output appears on that port's 4-bit field and stays there until the next grant. A granted output stays busy until its release input is pulsed. The arbiter accepts new requests only in the multi-queue mode setting. Output ports are released by their own inputs. A port may withdraw its pending request through a cancel input.

Top module: `mq_out_arbiter`

## Requirements
- R1: A new request is stored only while `mode_sel` equals binary 10. With any other value, `req_valid` has no effect and the request does not appear later.
- R2: A request carries a 16-bit output mask on `req_mask[p*16 +: 16]` for port p, with bit o naming output o. An all-zero mask is ignored. A port holds at most one pending request.
- R3: A request that finds a free target gets `grant_ack` high in the cycle after the third rising edge that counts from the edge that sampled `req_valid`: one edge stores it, one reserves, one picks.
- R4: Outputs reserved for a port but not picked become free for reservation by other ports at the edge that follows the pick edge.
- R5: A request that wins no output stays pending and is re-arbitrated on every cycle until it is granted or cancelled.
- R6: `grant_ack[p]` is high for exactly one cycle per grant. In the next cycle, `grant_num[p*4 +: 4]` shows the granted output number, and it holds that value until the port's next grant.
- R7: In the reserve stage, ports are scanned for each free output starting from a global pointer that advances by one, modulo 16, in every cycle in which any reservation is made. No output is granted to two ports.
- R8: In the pick stage, a port searches its reserved outputs in ascending order with wrap-around. The search starts one above the output last granted to that port.
- R9: A granted output is busy and cannot be reserved until `out_release` for it is pulsed. After the release edge, it is reservable at the next edge.
- R10: A new mask from a port with a pending request is ignored. `cancel` drops a pending request unless a reservation for it is in flight, and a cancelling port reserves nothing in that cycle.
- R11: Reset, which is synchronous and active-high, clears pending requests, reservations and busy flags, sets every pointer to 0, and drives `grant_ack` and `grant_num` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Operating mode; arbitration of new requests only at binary 10 |
| req_valid | input | 16 | Per input port: new request strobe |
| req_mask | input | 256 | Per input port: 16-bit requested output mask |
| cancel | input | 16 | Per input port: drop the pending request |
| out_release | input | 16 | Per output port: free a busy output |
| grant_ack | output | 16 | Per input port: one-cycle grant pulse |
| grant_num | output | 64 | Per input port: 4-bit granted output number |

## Verification
A pending flag that is lost or stuck shows up as a missing or extra acknowledge two to three cycles after the request. A busy flag that is cleared too early shows up at once as an output granted to a second port. A round-robin pointer or global priority pointer that is off by one does not break any protocol rule. It shows only in which output or which port wins, in the grant number one cycle after the acknowledge. For that reason, a cycle-accurate model compares every acknowledge and grant number on every clock during long random traffic. Directed cases pin down wrap-around, release timing and the cancel and mode gates.

// File: rtl/mqa_pkg.sv
package mqa_pkg;
  typedef logic [1:0] mode_t;
  localparam mode_t MODE_MULTI_Q = 2'b10;
endpackage

// File: rtl/mqa_req_store.sv
module mqa_req_store #(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_on,
  input  logic [N-1:0]   req_valid,
  input  logic [N*N-1:0] req_mask,
  input  logic [N-1:0]   cancel,
  input  logic [N-1:0]   got,
  output logic [N-1:0]   pend,
  output logic [N-1:0]   pmask [N]
);
  for (genvar p = 0; p < N; p++) begin : g_port
    logic [N-1:0] new_mask;
    assign new_mask = req_mask[p*N +: N];
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[p]  <= 1'b0;
        pmask[p] <= '0;
      end else if (got[p]) begin
        pend[p] <= 1'b0;
      end else if (pend[p] && cancel[p]) begin
        pend[p] <= 1'b0;
      end else if (!pend[p] && mode_on && req_valid[p] && (new_mask != '0)) begin
        pend[p]  <= 1'b1;
        pmask[p] <= new_mask;
      end
    end
  end
endmodule

// File: rtl/mqa_reserve.sv
module mqa_reserve #(
  parameter int N = 16,
  localparam int PW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_on,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] cancel,
  input  logic [N-1:0] busy,
  input  logic [N-1:0] pmask [N],
  output logic [N-1:0] res [N]
);
  logic [PW-1:0] gptr;
  logic [N-1:0]  held;
  logic [N-1:0]  elig;
  logic [N-1:0]  nres [N];
  logic [PW-1:0] idx;
  logic          taken;
  logic          any_res;

  always_comb begin
    held = '0;
    for (int p = 0; p < N; p++) begin
      held    |= res[p];
      elig[p]  = mode_on & pend[p] & ~cancel[p] & ~(|res[p]);
      nres[p]  = '0;
    end
    idx   = '0;
    taken = 1'b0;
    for (int o = 0; o < N; o++) begin
      taken = busy[o] | held[o];
      for (int k = 0; k < N; k++) begin
        idx = gptr + PW'(k);
        if (!taken && elig[idx] && pmask[idx][o]) begin
          nres[idx][o] = 1'b1;
          taken = 1'b1;
        end
      end
    end
    any_res = 1'b0;
    for (int p = 0; p < N; p++) any_res |= |nres[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gptr <= '0;
      for (int p = 0; p < N; p++) res[p] <= '0;
    end else begin
      if (any_res) gptr <= gptr + 1'b1;
      for (int p = 0; p < N; p++) res[p] <= nres[p];
    end
  end
endmodule

// File: rtl/mqa_pick.sv
module mqa_pick #(
  parameter int N = 16,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  res [N],
  output logic [N-1:0]  got,
  output logic [PW-1:0] win [N]
);
  logic [PW-1:0] rr [N];

  for (genvar p = 0; p < N; p++) begin : g_port
    logic [PW-1:0] idx;
    always_comb begin
      got[p] = |res[p];
      win[p] = rr[p];
      idx    = '0;
      for (int k = N; k >= 1; k--) begin
        idx = rr[p] + PW'(k);
        if (res[p][idx]) win[p] = idx;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)         rr[p] <= '0;
      else if (got[p]) rr[p] <= win[p];
    end
  end
endmodule

// File: rtl/mq_out_arbiter.sv
module mq_out_arbiter #(
  parameter int N = 16,
  localparam int PW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_sel,
  input  logic [N-1:0]    req_valid,
  input  logic [N*N-1:0]  req_mask,
  input  logic [N-1:0]    cancel,
  input  logic [N-1:0]    out_release,
  output logic [N-1:0]    grant_ack,
  output logic [N*PW-1:0] grant_num
);
  import mqa_pkg::*;

  logic          mode_on;
  logic [N-1:0]  pend;
  logic [N-1:0]  pmask [N];
  logic [N-1:0]  res [N];
  logic [N-1:0]  got;
  logic [PW-1:0] win [N];
  logic [PW-1:0] pick_q [N];
  logic [N-1:0]  busy;
  logic [N-1:0]  set_mask;

  assign mode_on = (mode_sel == MODE_MULTI_Q);

  mqa_req_store #(.N(N)) i_store (
    .clk(clk), .rst(rst), .mode_on(mode_on), .req_valid(req_valid),
    .req_mask(req_mask), .cancel(cancel), .got(got),
    .pend(pend), .pmask(pmask)
  );

  mqa_reserve #(.N(N)) i_reserve (
    .clk(clk), .rst(rst), .mode_on(mode_on), .pend(pend), .cancel(cancel),
    .busy(busy), .pmask(pmask), .res(res)
  );

  mqa_pick #(.N(N)) i_pick (
    .clk(clk), .rst(rst), .res(res), .got(got), .win(win)
  );

  always_comb begin
    set_mask = '0;
    for (int p = 0; p < N; p++)
      if (got[p]) set_mask[win[p]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= '0;
      grant_ack <= '0;
      grant_num <= '0;
      for (int p = 0; p < N; p++) pick_q[p] <= '0;
    end else begin
      busy      <= (busy & ~out_release) | set_mask;
      grant_ack <= got;
      for (int p = 0; p < N; p++) begin
        pick_q[p] <= win[p];
        if (grant_ack[p]) grant_num[p*PW +: PW] <= pick_q[p];
      end
    end
  end
endmodule

// File: rtl/mqa_checker.sv
module mqa_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_sel,
  input logic [N-1:0] grant_ack,
  input logic [N-1:0] pend,
  input logic [N-1:0] busy,
  input logic [N-1:0] set_mask,
  input logic [N-1:0] got,
  input logic [N-1:0] cancel,
  input logic [N-1:0] out_release
);
  import mqa_pkg::*;

  a_r1_mode_gate: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != MODE_MULTI_Q) |=> ((pend & ~$past(pend)) == '0));

  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
    (grant_ack != '0) |=> ((grant_ack & $past(grant_ack)) == '0));

  a_r7_unique_grant: assert property (@(posedge clk) disable iff (rst)
    (got != '0) |-> ($countones(set_mask) == $countones(got)));

  a_r9_no_busy_regrant: assert property (@(posedge clk) disable iff (rst)
    (got != '0) |-> ((set_mask & busy) == '0));

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy != '0) |=> ((($past(busy) & ~$past(out_release)) & ~busy) == '0));

  a_r10_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |=> (($past(pend) & ~pend & ~$past(got | cancel)) == '0));
endmodule

bind mq_out_arbiter mqa_checker #(.N(N)) i_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .grant_ack(grant_ack),
  .pend(pend), .busy(busy), .set_mask(set_mask), .got(got),
  .cancel(cancel), .out_release(out_release)
);

// File: tb/test_mq_out_arbiter.sv
module test_mq_out_arbiter;
  localparam int N  = 16;
  localparam int PW = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [1:0]      mode;
  logic [N-1:0]    rv, canc, rel;
  logic [N*N-1:0]  rmask;
  logic [N-1:0]    grant_ack;
  logic [N*PW-1:0] grant_num;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mq_out_arbiter #(.N(N)) i_mq_out_arbiter (
    .clk(clk), .rst(rst), .mode_sel(mode), .req_valid(rv), .req_mask(rmask),
    .cancel(canc), .out_release(rel), .grant_ack(grant_ack), .grant_num(grant_num)
  );

  // behavioural reference model, bitmasks held in ints
  int m_pend[N], m_mask[N], m_res[N], m_rr[N], m_pick[N], m_gport[N];
  int m_busy, m_gptr, m_ack;
  int held, setm, gotm, fnd, o2, p2, anyr;
  int nres[N], win[N];

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N; p++) begin
        m_pend[p] = 0; m_mask[p] = 0; m_res[p] = 0;
        m_rr[p] = 0; m_pick[p] = 0; m_gport[p] = 0;
      end
      m_busy = 0; m_gptr = 0; m_ack = 0;
    end else begin
      held = 0; setm = 0; gotm = 0; anyr = 0;
      for (int p = 0; p < N; p++) held |= m_res[p];
      for (int p = 0; p < N; p++) begin
        nres[p] = 0; win[p] = m_rr[p]; fnd = 0;
        for (int k = 1; k <= N; k++) begin
          o2 = (m_rr[p] + k) % N;
          if (!fnd && ((m_res[p] >> o2) & 1) == 1) begin win[p] = o2; fnd = 1; end
        end
        if (m_res[p] != 0) begin gotm |= 1 << p; setm |= 1 << win[p]; end
      end
      for (int o = 0; o < N; o++) begin
        if (((m_busy >> o) & 1) == 0 && ((held >> o) & 1) == 0) begin
          fnd = 0;
          for (int k = 0; k < N; k++) begin
            p2 = (m_gptr + k) % N;
            if (!fnd && mode == 2'b10 && m_pend[p2] == 1 && !canc[p2] &&
                m_res[p2] == 0 && ((m_mask[p2] >> o) & 1) == 1) begin
              nres[p2] |= 1 << o; fnd = 1; anyr = 1;
            end
          end
        end
      end
      for (int p = 0; p < N; p++) begin
        if (((m_ack >> p) & 1) == 1) m_gport[p] = m_pick[p];
        if (((gotm >> p) & 1) == 1) m_pend[p] = 0;
        else if (m_pend[p] == 1 && canc[p]) m_pend[p] = 0;
        else if (m_pend[p] == 0 && mode == 2'b10 && rv[p] && rmask[p*N +: N] != 0) begin
          m_pend[p] = 1; m_mask[p] = int'(rmask[p*N +: N]);
        end
        if (((gotm >> p) & 1) == 1) begin m_rr[p] = win[p]; m_pick[p] = win[p]; end
        m_res[p] = nres[p];
      end
      m_busy = (m_busy & ~int'(rel)) | setm;
      m_ack  = gotm;
      if (anyr) m_gptr = (m_gptr + 1) % N;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      int bad;
      bad = 0;
      checks++;
      if (int'(grant_ack) != m_ack) bad = 1;
      for (int p = 0; p < N; p++) if (int'(grant_num[p*PW +: PW]) != m_gport[p]) bad = 1;
      if (bad) begin
        errors++;
        $display("FAIL R6 R7 R8 model compare: ack actual %h expected %h, nums actual %h",
                 grant_ack, m_ack[N-1:0], grant_num);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int gp(int p);
    return int'(grant_num[p*PW +: PW]);
  endfunction

  task automatic set_req(int p, int m);
    rv[p] = 1'b1;
    rmask[p*N +: N] = m[N-1:0];
  endtask

  task automatic pulse_rel(int o);
    rel[o] = 1'b1; tick(1); rel = '0;
  endtask

  initial begin
    rst = 1'b1; mode = 2'b10; rv = '0; canc = '0; rel = '0; rmask = '0;
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R11 reset ack", int'(grant_ack), 0);
    chk("R11 reset grant number", int'(grant_num != '0), 0);

    // R2 R3 R8: port 0 asks for outputs 1 and 2
    set_req(0, 'h0006); tick(1); rv = '0;
    tick(1); chk("R3 ack not before third edge", int'(grant_ack[0]), 0);
    tick(1); chk("R3 ack after third edge", int'(grant_ack[0]), 1);
    tick(1); chk("R6 ack one cycle", int'(grant_ack[0]), 0);
    chk("R8 first grant from pointer 0", gp(0), 1);
    pulse_rel(1);
    set_req(0, 'h0006); tick(1); rv = '0; tick(3);
    chk("R8 search above last grant", gp(0), 2);
    pulse_rel(2);
    set_req(0, 'h0006); tick(1); rv = '0; tick(3);
    chk("R8 search wraps", gp(0), 1);

    // R5 R9: port 1 blocked on busy output 1
    begin
      int seen;
      seen = 0;
      set_req(1, 'h0002); tick(1); rv = '0;
      for (int i = 0; i < 10; i++) begin tick(1); if (grant_ack[1]) seen = 1; end
      chk("R9 busy output not granted", seen, 0);
    end
    pulse_rel(1);
    tick(1); chk("R9 not yet reserved", int'(grant_ack[1]), 0);
    tick(1); chk("R5 blocked request granted after release", int'(grant_ack[1]), 1);
    tick(1); chk("R5 granted number", gp(1), 1);

    // R1: mode gate
    mode = 2'b00;
    set_req(4, 'h0100); tick(1); rv = '0; tick(5);
    chk("R1 no grant in other mode", int'(grant_ack[4]), 0);
    mode = 2'b10; tick(6);
    chk("R1 request not stored", gp(4), 0);
    set_req(4, 'h0100); tick(1); rv = '0; tick(3);
    chk("R1 grant in multi-queue mode", gp(4), 8);

    // R10: new mask while pending, then cancel
    set_req(6, 'h0002); tick(1); rv = '0; tick(2);
    set_req(6, 'h0080); tick(1); rv = '0; tick(5);
    chk("R10 new mask ignored while pending", gp(6), 0);
    canc[6] = 1'b1; tick(1); canc = '0;
    pulse_rel(1); tick(5);
    chk("R10 cancelled request not granted", gp(6), 0);
    set_req(6, 'h0080); tick(1); rv = '0; tick(3);
    chk("R10 request after cancel", gp(6), 7);

    // R7: two ports race for output 5
    set_req(2, 'h0020); set_req(3, 'h0020); tick(1); rv = '0; tick(2);
    chk("R7 single winner", $countones(grant_ack[3:2]), 1);
    tick(2); pulse_rel(5); tick(5);
    chk("R7 port 2 served", gp(2), 5);
    chk("R7 port 3 served", gp(3), 5);

    // R4: unpicked reservation released to another port
    set_req(8, 'h0C00); set_req(9, 'h0800); tick(1); rv = '0; tick(5);
    chk("R4 port 8 number", gp(8), 10);
    chk("R4 released output reaches port 9", gp(9), 11);

    // random traffic against the model (R2 R5 R7 R9 R10)
    rel = '1; tick(1); rel = '0;
    for (int c = 0; c < 3000; c++) begin
      mode = ($urandom % 60 == 0) ? 2'b01 : 2'b10;
      for (int p = 0; p < N; p++) begin
        rv[p] = ($urandom % 6 == 0);
        rmask[p*N +: N] = N'($urandom & $urandom);
        canc[p] = ($urandom % 40 == 0);
      end
      rel = N'($urandom & $urandom & $urandom);
      tick(1);
    end
    rv = '0; canc = '0; rel = '0; mode = 2'b10;
    tick(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule